// File: doc/BRIEF.md
# Sample FIFO with Block-Count Interrupt

This block sits between an analog-to-digital converter and a host bus. The converter pushes one 16-bit result per cycle through a simple write strobe. The host reaches the block through a small register port. The host can pop samples, read a packed flag word, program a block counter and service a single latched interrupt source.

The block counter lets the host move data in fixed-size blocks rather than sample by sample. It is loaded with N-1 and then fires once for every N samples the FIFO accepts. It reloads itself after each event and keeps firing until the host stops it. Each event latches a status bit. That bit drives the interrupt line only when its enable bit is set.

An overflowing write is dropped and recorded in a sticky overrun flag. The host can empty the FIFO and clear the overrun flag with dedicated register writes.

The depth is a power-of-two parameter, with 1024 and 8192 as the intended sizes. Software can find the depth at run time: it writes samples until the half-empty flag falls, then doubles that count.

Top module: `smp_fifo_irq`

## Requirements
- R1: Samples accepted from the converter port are returned in arrival order by host reads of register address 0, one sample per read, with the value on `host_rdata` in the cycle after the read strobe.
- R2: A read of address 1 returns a flag word with bit 8 = FIFO not empty, bit 9 = fewer than DEPTH/2 entries held (half-empty), bit 10 = fewer than DEPTH entries held (not full), and all other bits 0. The word reflects the fill level before the read's clock edge.
- R3: A converter write when the FIFO already holds DEPTH entries is dropped, even if a pop happens in the same cycle. The fill level is unchanged, and the overrun flag (bit 0 of a read of address 7) becomes 1.
- R4: A read of address 0 while the FIFO is empty returns the last sample previously popped (0 after reset) and changes neither the fill level nor the flags.
- R5: A host write to address 6 empties the FIFO. A converter write in the same cycle is discarded and does not set the overrun flag.
- R6: A host write of value V to address 4 loads the block counter with V and starts it. While it runs, every accepted converter write decrements it, and an accepted write that finds it at 0 reloads V and sets interrupt status bit 4. An event therefore occurs every V+1 accepted writes. A read of address 4 returns the current count.
- R7: A host write to address 5 stops the block counter. A stopped counter, and dropped converter writes, raise no event and leave the count unchanged.
- R8: Address 2 holds a 16-bit interrupt enable mask (read/write). The `irq` output is 1 exactly when some bit is set both in the status register (read at address 3) and in the enable mask.
- R9: A host write of a mask to address 3 clears the status bits set in the mask, and writing all ones clears all of them. A block event in the same cycle still sets bit 4.
- R10: A host write to address 7 clears the overrun flag, unless a dropped write sets it again in the same cycle.
- R11: After reset the FIFO is empty. The flag word reads 0x0600, and the status, enable mask, count and overrun flag read 0. `irq` is 0 and the block counter is stopped.
- R12: Writing samples into an empty FIFO until the half-empty flag reads 0 takes exactly DEPTH/2 writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cv_wr_en | input | 1 | Converter write strobe |
| cv_wr_data | input | DW | Converter sample |
| host_wr_en | input | 1 | Host register write strobe |
| host_rd_en | input | 1 | Host register read strobe |
| host_addr | input | 3 | Host register address |
| host_wdata | input | DW | Host write data |
| host_rdata | output | DW | Host read data, valid the cycle after the read strobe |
| irq | output | 1 | Interrupt: status AND enable, reduced by OR |

## Verification
The bench aims at the edges of the fill level.
- At exactly DEPTH/2 entries, a design with an off-by-one comparator drops half-empty one write early or late, and the depth probe returns the wrong size.
- At DEPTH entries, a design that lets a concurrent pop make room accepts a write it should drop.
- A design that does not guard the empty pop corrupts its pointers and returns a stale value.

The block counter is checked in several ways:
- It fires on the (N)th accepted write and then repeats.
- It ignores dropped writes and stops when told.
- An event that coincides with a clear-all write must survive; a design that orders the clear after the set loses that interrupt.

// File: rtl/smp_fifo_pkg.sv
package smp_fifo_pkg;

    // Host register addresses
    typedef enum logic [2:0] {
        REG_SAMPLE   = 3'd0,
        REG_FLAGS    = 3'd1,
        REG_IRQ_EN   = 3'd2,
        REG_IRQ_STAT = 3'd3,
        REG_BLK_LOAD = 3'd4,
        REG_BLK_STOP = 3'd5,
        REG_FIFO_CLR = 3'd6,
        REG_OVERRUN  = 3'd7
    } reg_sel_e;

    // Flag word bit positions decoded by host software
    localparam int FLAG_NOT_EMPTY  = 8;
    localparam int FLAG_HALF_EMPTY = 9;
    localparam int FLAG_NOT_FULL   = 10;

    // Interrupt status bit raised by the block counter
    localparam int IRQ_BLOCK_BIT   = 4;

endpackage

// File: rtl/smp_fifo_store.sv
module smp_fifo_store #(
    parameter int DW    = 16,
    parameter int DEPTH = 1024
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        push_req,
    input  logic [DW-1:0]               push_data,
    input  logic                        pop_req,
    input  logic                        clr,
    input  logic                        ovf_clr,
    output logic [DW-1:0]               head_data,
    output logic [$clog2(DEPTH):0]      level,
    output logic                        push_ok,
    output logic                        pop_ok,
    output logic                        ovf
);
    localparam int AW = $clog2(DEPTH);
    localparam int LW = AW + 1;

    typedef struct packed {
        logic [AW-1:0] wr_ptr;
        logic [AW-1:0] rd_ptr;
        logic [LW-1:0] level;
        logic          ovf;
    } store_st_t;

    store_st_t st_d, st_q;
    logic [DW-1:0] mem [DEPTH];
    logic full, empty, drop;

    always_comb begin
        full    = (st_q.level == LW'(DEPTH));
        empty   = (st_q.level == '0);
        push_ok = push_req && !full && !clr;
        pop_ok  = pop_req && !empty;
        drop    = push_req && full && !clr;
        st_d    = st_q;
        if (clr) begin
            st_d.wr_ptr = '0;
            st_d.rd_ptr = '0;
            st_d.level  = '0;
        end else begin
            if (push_ok) st_d.wr_ptr = st_q.wr_ptr + AW'(1);
            if (pop_ok)  st_d.rd_ptr = st_q.rd_ptr + AW'(1);
            st_d.level = st_q.level + LW'(push_ok) - LW'(pop_ok);
        end
        if (drop)         st_d.ovf = 1'b1;
        else if (ovf_clr) st_d.ovf = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[st_q.wr_ptr] <= push_data;
    end

    assign head_data = mem[st_q.rd_ptr];
    assign level     = st_q.level;
    assign ovf       = st_q.ovf;

    // R3: the fill level never exceeds the depth
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.level <= LW'(DEPTH));

    // R3: a write into a full FIFO is dropped and latches overrun
    a_r3_drop_latches: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.level == LW'(DEPTH) && push_req && !pop_req && !clr)
        |=> (st_q.ovf && st_q.level == LW'(DEPTH)));

    // R5: a clear leaves the FIFO empty
    a_r5_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (st_q.level == '0));

    // R4: popping an empty FIFO moves nothing
    a_r4_empty_pop_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && st_q.level == '0 && !push_req) |=> (st_q.level == '0 && $stable(st_q.rd_ptr)));

    // R10: the overrun clear works when no drop coincides
    a_r10_ovf_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_clr && !(push_req && st_q.level == LW'(DEPTH) && !clr)) |=> !st_q.ovf);

endmodule

// File: rtl/smp_blk_counter.sv
module smp_blk_counter #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          stop,
    input  logic          tick,
    output logic          evt,
    output logic [CW-1:0] count
);
    typedef struct packed {
        logic          run;
        logic [CW-1:0] reload;
        logic [CW-1:0] cnt;
    } blk_st_t;

    blk_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        evt  = 1'b0;
        if (load) begin
            st_d.run    = 1'b1;
            st_d.reload = load_val;
            st_d.cnt    = load_val;
        end else if (stop) begin
            st_d.run = 1'b0;
        end else if (tick && st_q.run) begin
            if (st_q.cnt == '0) begin
                evt      = 1'b1;
                st_d.cnt = st_q.reload;
            end else begin
                st_d.cnt = st_q.cnt - CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count = st_q.cnt;

    // R6: after an event the counter restarts from the reload value
    a_r6_reload_after_event: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> (st_q.cnt == st_q.reload && st_q.run));

    // R6: each counted write steps the counter down by one
    a_r6_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && st_q.run && st_q.cnt != '0 && !load && !stop)
        |=> (st_q.cnt == $past(st_q.cnt) - CW'(1)));

    // R7: a stopped counter holds its value
    a_r7_stopped_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.run && !load) |=> $stable(st_q.cnt));

endmodule

// File: rtl/smp_irq_regs.sv
module smp_irq_regs #(
    parameter int SW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_wr,
    input  logic          clr_wr,
    input  logic [SW-1:0] wdata,
    input  logic [SW-1:0] set_vec,
    output logic [SW-1:0] stat,
    output logic [SW-1:0] en,
    output logic          irq
);
    typedef struct packed {
        logic [SW-1:0] stat;
        logic [SW-1:0] en;
    } irq_st_t;

    irq_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (en_wr)  st_d.en   = wdata;
        if (clr_wr) st_d.stat = st_q.stat & ~wdata;
        st_d.stat = st_d.stat | set_vec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stat = st_q.stat;
    assign en   = st_q.en;
    assign irq  = |(st_q.stat & st_q.en);

    // R9: a raised source is latched even when a clear coincides
    a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != '0) |=> ((st_q.stat & $past(set_vec)) == $past(set_vec)));

    // R9: cleared bits read back as zero
    a_r9_clear_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && set_vec == '0) |=> ((st_q.stat & $past(wdata)) == '0));

    // R8: with nothing enabled the line stays low
    a_r8_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.en == '0) |-> !irq);

endmodule

// File: rtl/smp_fifo_irq.sv
module smp_fifo_irq
    import smp_fifo_pkg::*;
#(
    parameter int DEPTH = 1024,
    parameter int DW    = 16,
    parameter int CNT_W = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cv_wr_en,
    input  logic [DW-1:0] cv_wr_data,
    input  logic          host_wr_en,
    input  logic          host_rd_en,
    input  logic [2:0]    host_addr,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_rdata,
    output logic          irq
);
    localparam int LW = $clog2(DEPTH) + 1;

    typedef struct packed {
        logic [DW-1:0] rdata;
        logic [DW-1:0] last;
    } top_st_t;

    top_st_t       top_d, top_q;
    reg_sel_e      sel;
    logic          pop_req, fifo_clr, ovf_clr, blk_load, blk_stop;
    logic          en_wr, stat_clr;
    logic [DW-1:0] head_data, flags, rd_val, set_vec, stat, en;
    logic [LW-1:0] level;
    logic          push_ok, pop_ok, ovf, blk_evt;
    logic [CNT_W-1:0] blk_count;

    assign sel = reg_sel_e'(host_addr);

    always_comb begin
        pop_req  = host_rd_en && (sel == REG_SAMPLE);
        fifo_clr = host_wr_en && (sel == REG_FIFO_CLR);
        ovf_clr  = host_wr_en && (sel == REG_OVERRUN);
        blk_load = host_wr_en && (sel == REG_BLK_LOAD);
        blk_stop = host_wr_en && (sel == REG_BLK_STOP);
        en_wr    = host_wr_en && (sel == REG_IRQ_EN);
        stat_clr = host_wr_en && (sel == REG_IRQ_STAT);
    end

    smp_fifo_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_req  (cv_wr_en),
        .push_data (cv_wr_data),
        .pop_req   (pop_req),
        .clr       (fifo_clr),
        .ovf_clr   (ovf_clr),
        .head_data (head_data),
        .level     (level),
        .push_ok   (push_ok),
        .pop_ok    (pop_ok),
        .ovf       (ovf)
    );

    smp_blk_counter #(.CW(CNT_W)) u_blk (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (blk_load),
        .load_val (CNT_W'(host_wdata)),
        .stop     (blk_stop),
        .tick     (push_ok),
        .evt      (blk_evt),
        .count    (blk_count)
    );

    always_comb begin
        set_vec = '0;
        set_vec[IRQ_BLOCK_BIT] = blk_evt;
    end

    smp_irq_regs #(.SW(DW)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_wr   (en_wr),
        .clr_wr  (stat_clr),
        .wdata   (host_wdata),
        .set_vec (set_vec),
        .stat    (stat),
        .en      (en),
        .irq     (irq)
    );

    always_comb begin
        flags = '0;
        flags[FLAG_NOT_EMPTY]  = (level != '0);
        flags[FLAG_HALF_EMPTY] = (level < LW'(DEPTH / 2));
        flags[FLAG_NOT_FULL]   = (level < LW'(DEPTH));

        unique case (sel)
            REG_SAMPLE:   rd_val = pop_ok ? head_data : top_q.last;
            REG_FLAGS:    rd_val = flags;
            REG_IRQ_EN:   rd_val = en;
            REG_IRQ_STAT: rd_val = stat;
            REG_BLK_LOAD: rd_val = DW'(blk_count);
            REG_OVERRUN:  rd_val = DW'(ovf);
            default:      rd_val = '0;
        endcase

        top_d       = top_q;
        top_d.rdata = host_rd_en ? rd_val : top_q.rdata;
        top_d.last  = pop_ok ? head_data : top_q.last;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

    assign host_rdata = top_q.rdata;

    // R4: an empty sample read returns the last popped value
    a_r4_empty_read_last: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd_en && host_addr == 3'd0 && level == '0)
        |=> (host_rdata == $past(top_q.last)));

    // R2: half-empty and not-empty are never both low
    a_r2_flag_consistency: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[FLAG_NOT_EMPTY] || flags[FLAG_HALF_EMPTY]));

endmodule

// File: tb/smp_fifo_irq_tb.sv
`timescale 1ns/1ps
module smp_fifo_irq_tb;
    localparam int DEPTH = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cv_wr_en = 1'b0;
    logic [15:0] cv_wr_data = '0;
    logic        host_wr_en = 1'b0;
    logic        host_rd_en = 1'b0;
    logic [2:0]  host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        irq;

    int checks = 0;
    int fails  = 0;

    // reference model state
    logic [15:0] mq[$];
    bit          m_ovf = 0, m_run = 0;
    logic [15:0] m_stat = '0, m_en = '0, m_cnt = '0, m_reload = '0, m_last = '0;
    logic [15:0] got;

    smp_fifo_irq #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .cv_wr_en(cv_wr_en), .cv_wr_data(cv_wr_data),
        .host_wr_en(host_wr_en), .host_rd_en(host_rd_en), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .irq(irq)
    );

    always #5 clk = ~clk;

    task automatic check(input string tag, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // One clock: drive at negedge, model the edge, compare at the next negedge
    task automatic step(input bit cw, input logic [15:0] cwd, input bit hw, input bit hr,
                        input logic [2:0] a, input logic [15:0] wd, input string tag);
        int sz;
        bit clr, acc, drop, pop, ev;
        logic [15:0] exp_rd;
        cv_wr_en = cw; cv_wr_data = cwd; host_wr_en = hw; host_rd_en = hr;
        host_addr = a; host_wdata = wd;
        sz   = mq.size();
        clr  = hw && a == 3'd6;
        acc  = cw && !clr && sz < DEPTH;
        drop = cw && !clr && sz >= DEPTH;
        pop  = hr && a == 3'd0 && sz > 0;
        case (a)
            3'd0: exp_rd = pop ? mq[0] : m_last;
            3'd1: exp_rd = {5'b0, (sz < DEPTH), (sz < DEPTH/2), (sz > 0), 8'b0};
            3'd2: exp_rd = m_en;
            3'd3: exp_rd = m_stat;
            3'd4: exp_rd = m_cnt;
            3'd7: exp_rd = {15'b0, m_ovf};
            default: exp_rd = '0;
        endcase
        if (pop) m_last = mq[0];
        if (clr) mq.delete();
        else begin
            if (pop) void'(mq.pop_front());
            if (acc) mq.push_back(cwd);
        end
        if (drop) m_ovf = 1;
        else if (hw && a == 3'd7) m_ovf = 0;
        ev = 0;
        if (hw && a == 3'd4) begin m_reload = wd; m_cnt = wd; m_run = 1; end
        else if (hw && a == 3'd5) m_run = 0;
        else if (acc && m_run) begin
            if (m_cnt == 0) begin ev = 1; m_cnt = m_reload; end
            else m_cnt = m_cnt - 16'd1;
        end
        if (hw && a == 3'd3) m_stat = m_stat & ~wd;
        if (ev) m_stat[4] = 1'b1;
        if (hw && a == 3'd2) m_en = wd;
        @(posedge clk);
        @(negedge clk);
        got = host_rdata;
        if (hr) check(tag, $sformatf("rdata addr %0d", a), host_rdata, exp_rd);
        check(tag, "irq", {15'b0, irq}, {15'b0, |(m_stat & m_en)});
        cv_wr_en = 0; host_wr_en = 0; host_rd_en = 0;
    endtask

    task automatic wr(input logic [15:0] d, input string tag);
        step(1, d, 0, 0, 3'd0, 16'h0, tag);
    endtask
    task automatic rd(input logic [2:0] a, input string tag);
        step(0, 16'h0, 0, 1, a, 16'h0, tag);
    endtask
    task automatic wreg(input logic [2:0] a, input logic [15:0] v, input string tag);
        step(0, 16'h0, 1, 0, a, v, tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int probe;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R11 reset state
        rd(3'd1, "R11"); rd(3'd7, "R11"); rd(3'd3, "R11"); rd(3'd4, "R11"); rd(3'd2, "R11");

        // R1 ordering, R2 flags
        for (int i = 0; i < 5; i++) wr(16'hA100 + 16'(i), "R1");
        rd(3'd1, "R2");
        for (int i = 0; i < 5; i++) rd(3'd0, "R1");

        // R4 empty reads
        rd(3'd0, "R4"); rd(3'd0, "R4"); rd(3'd1, "R4");

        // R6 block events every 4 writes, R8 enabled
        wreg(3'd2, 16'h0010, "R8");
        wreg(3'd4, 16'd3, "R6");
        for (int i = 0; i < 10; i++) wr(16'h0B00 + 16'(i), "R6");
        rd(3'd3, "R6"); rd(3'd4, "R6");
        wreg(3'd3, 16'h0010, "R9"); rd(3'd3, "R9");

        // R9 event coinciding with clear-all
        wr(16'h0C01, "R9");
        step(1, 16'h0C02, 1, 0, 3'd3, 16'hFFFF, "R9");
        rd(3'd3, "R9");
        wreg(3'd3, 16'hFFFF, "R9"); rd(3'd3, "R9");

        // R8 masked source
        wreg(3'd2, 16'h0000, "R8");
        for (int i = 0; i < 4; i++) wr(16'h0D00 + 16'(i), "R8");
        rd(3'd3, "R8");
        wreg(3'd2, 16'h0010, "R8");
        wreg(3'd3, 16'hFFFF, "R8");

        // R7 stopped counter
        wreg(3'd5, 16'h0, "R7");
        for (int i = 0; i < 8; i++) wr(16'h0E00 + 16'(i), "R7");
        rd(3'd3, "R7"); rd(3'd4, "R7");

        // R5 clear
        wreg(3'd6, 16'h0, "R5"); rd(3'd1, "R5");

        // R12 depth probe
        probe = 0;
        for (int k = 1; k <= DEPTH; k++) begin
            wr(16'(k), "R12");
            rd(3'd1, "R12");
            if (!got[9]) begin probe = k; break; end
        end
        check("R12", "probed depth", 16'(2 * probe), 16'(DEPTH));

        // fill to full with a one-sample block counter running
        wreg(3'd4, 16'd0, "R6");
        while (mq.size() < DEPTH) wr(16'(mq.size()), "R2");
        rd(3'd1, "R2");
        wreg(3'd3, 16'hFFFF, "R9");
        // R3 drops, R7 drops do not count
        wr(16'hDEAD, "R3"); wr(16'hBEEF, "R3");
        rd(3'd3, "R7"); rd(3'd1, "R3"); rd(3'd7, "R3");
        step(1, 16'hFACE, 0, 1, 3'd0, 16'h0, "R3");
        rd(3'd1, "R3");

        // R10 overrun clear
        wreg(3'd7, 16'h0, "R10"); rd(3'd7, "R10");

        // R1 order after wrap
        for (int i = 0; i < 4; i++) rd(3'd0, "R1");

        // R5 clear beats a simultaneous write
        wreg(3'd5, 16'h0, "R5");
        step(1, 16'h1234, 1, 0, 3'd6, 16'h0, "R5");
        rd(3'd1, "R5"); rd(3'd7, "R5"); rd(3'd0, "R5");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule